// File: doc/BRIEF.md
# Sampling Phase Centering Controller

This block steers the input delay line of one serial video lane so that the sampling point lands in the middle of the valid data eye. Each clock it takes one 10-bit deserialized word. Pixel data is random, but the four link control characters recur all the time. The block counts a tap as well sampled when at least one control character shows up during an observation interval and no decode mismatch is flagged in that interval.

The delay element is modelled inside the block as a plain 6-bit tap register. An increment strobe advances the tap. A step-done acknowledge follows each increment, and an overflow pulse marks a step past the last tap. The controller first leaves any valid window it starts in. It then records T1, the first good tap, and T2, the first failing tap after T1. Finally it loads the tap midway between them and raises a lock flag. The lock is held until reset or a loss-of-lock input. If the scan overflows before both edges are found, it starts again from tap 0 with the lock low.

Top module: `eye_center_ctrl`

## Requirements
- R1: A tap is judged good when, within OBS_WORDS consecutive words, at least one word equals one of 10'h354, 10'h0AB, 10'h154 or 10'h2AB (bit 0 is the first bit received) and `decode_err` is never high. Control characters seen while `decode_err` is high do not make the tap good.
- R2: Each delay step is a one-cycle `tap_inc` pulse. Below tap 63, `tap_val` is one higher in the following cycle. From reset to lock, the number of pulses equals T2.
- R3: `step_done` pulses exactly one cycle after every `tap_inc`. Observation at the new tap starts only after that pulse.
- R4: A step taken at tap 63 raises `tap_ovf` in the same cycle and returns the tap to 0. The scan then restarts from its initial phase and `lock` stays low.
- R5: When tap 0 is bad, the scan steps until the first good tap (T1), then keeps stepping until the first bad tap (T2).
- R6: When tap 0 is good, the scan first steps until a bad tap and only then searches for T1 and T2.
- R7: On finding T2 the tap is loaded with floor((T1+T2)/2), and `lock` rises in the same cycle.
- R8: While `lock` is high and `lock_lost` is low, `tap_val` stays constant and no `tap_inc` occurs, whatever words arrive.
- R9: `lock_lost` while locked drops `lock` and returns the tap to 0 on the next cycle, after which a fresh scan can lock again.
- R10: After reset, `tap_val` is 0, `lock` is low and neither `tap_inc` nor `step_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_in | input | 10 | Deserialized lane word, one per cycle |
| decode_err | input | 1 | Decode mismatch flag for the current word |
| lock_lost | input | 1 | Request to drop lock and rescan |
| tap_inc | output | 1 | One-cycle delay increment strobe |
| step_done | output | 1 | Acknowledge one cycle after each increment |
| tap_ovf | output | 1 | Pulse when a step wraps past the last tap |
| tap_val | output | 6 | Current delay tap |
| lock | output | 1 | Sampling point centered and held |

## Verification
The bench models the eye as up to two tap windows that carry control characters among random data, and it drives the words that match the current tap. A window beginning above tap 0 exercises the jitter-start path. A window beginning at tap 0 with a second window higher up shows whether the initial window is skipped, and the pair of results separates T1/T2 recording from the centering arithmetic. A one-tap window and an odd-width window check the rounding. Windows that run to tap 63, cover every tap, or show control characters together with decode errors must never lock and must produce overflow. The last group tells the overflow restart apart from the rule that errors override control characters.

// File: rtl/eye_center_ctrl.sv
module eye_center_ctrl #(
  parameter int TAP_W     = 6,
  parameter int OBS_WORDS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [9:0]       word_in,
  input  logic             decode_err,
  input  logic             lock_lost,
  output logic             tap_inc,
  output logic             step_done,
  output logic             tap_ovf,
  output logic [TAP_W-1:0] tap_val,
  output logic             lock
);
  localparam int CNT_W = (OBS_WORDS > 2) ? $clog2(OBS_WORDS) : 1;
  localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(OBS_WORDS - 1);

  typedef enum logic [1:0] {S_OBS, S_STEP, S_WAIT, S_LOCK} state_t;
  typedef enum logic [1:0] {P_INIT, P_SKIP, P_SEEK1, P_SEEK2} phase_t;

  state_t           state;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             seen_ctl, seen_err;
  logic [TAP_W-1:0] t1;
  logic [TAP_W:0]   edge_sum;
  logic             is_ctl, good, obs_end;

  assign is_ctl   = (word_in == 10'h354) || (word_in == 10'h0AB) ||
                    (word_in == 10'h154) || (word_in == 10'h2AB);
  assign good     = (seen_ctl | is_ctl) & ~(seen_err | decode_err);
  assign obs_end  = (cnt == CNT_END);
  assign edge_sum = {1'b0, t1} + {1'b0, tap_val};
  assign tap_inc  = (state == S_STEP);
  assign tap_ovf  = tap_inc && (tap_val == TAP_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_OBS;
      phase     <= P_INIT;
      cnt       <= '0;
      seen_ctl  <= 1'b0;
      seen_err  <= 1'b0;
      t1        <= '0;
      tap_val   <= '0;
      lock      <= 1'b0;
      step_done <= 1'b0;
    end else begin
      step_done <= tap_inc;
      case (state)
        S_OBS: begin
          cnt      <= cnt + 1'b1;
          seen_ctl <= seen_ctl | is_ctl;
          seen_err <= seen_err | decode_err;
          if (obs_end) begin
            cnt      <= '0;
            seen_ctl <= 1'b0;
            seen_err <= 1'b0;
            if (phase == P_SEEK2 && !good) begin
              tap_val <= edge_sum[TAP_W:1];
              lock    <= 1'b1;
              state   <= S_LOCK;
            end else begin
              state <= S_STEP;
              case (phase)
                P_INIT:  phase <= good ? P_SKIP : P_SEEK1;
                P_SKIP:  if (!good) phase <= P_SEEK1;
                P_SEEK1: if (good) begin
                  t1    <= tap_val;
                  phase <= P_SEEK2;
                end
                default: ;
              endcase
            end
          end
        end
        S_STEP: begin
          if (tap_val == TAP_MAX) begin
            tap_val <= '0;
            phase   <= P_INIT;
          end else begin
            tap_val <= tap_val + 1'b1;
          end
          state <= S_WAIT;
        end
        S_WAIT: if (step_done) state <= S_OBS;
        S_LOCK: if (lock_lost) begin
          lock    <= 1'b0;
          tap_val <= '0;
          phase   <= P_INIT;
          state   <= S_OBS;
        end
        default: state <= S_OBS;
      endcase
    end
  end

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    tap_inc && tap_val != TAP_MAX |=> tap_val == $past(tap_val) + 1'b1); // R2
  AST_STEP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    tap_inc |=> step_done && !tap_inc); // R3
  AST_ACK_ONLY_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_inc |=> !step_done); // R3
  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    tap_inc && tap_val == TAP_MAX |=> tap_val == '0 && !lock); // R4
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !lock_lost |=> lock && $stable(tap_val)); // R8
  AST_NO_STEP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !tap_inc); // R8
  AST_LOST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    lock && lock_lost |=> !lock && tap_val == '0); // R9
endmodule

// File: tb/eye_center_ctrl_bench.sv
module eye_center_ctrl_bench;
  localparam int NV = 7;
  localparam int OBS = 8;
  // a1, b1, a2, b2, err_in_win2, exp_lock, exp_center
  localparam int VEC [NV][7] = '{
    '{12, 30,  0,  0, 0, 1, 21},
    '{ 0, 10, 25, 45, 0, 1, 35},
    '{ 5, 12,  0,  0, 0, 1,  8},
    '{40, 41,  0,  0, 0, 1, 40},
    '{ 0, 10, 25, 45, 1, 0,  0},
    '{50, 64,  0,  0, 0, 0,  0},
    '{ 0, 64,  0,  0, 0, 0,  0}
  };
  localparam logic [9:0] CTL [4] = '{10'h354, 10'h0AB, 10'h154, 10'h2AB};

  logic clk = 0, rst_n = 0, decode_err = 0, lock_lost = 0;
  logic [9:0] word_in = 10'h0;
  logic tap_inc, step_done, tap_ovf, lock;
  logic [5:0] tap_val;

  int total = 0, bad = 0, cyc = 0;
  int a1 = 0, b1 = 0, a2 = 0, b2 = 0, e2 = 0;
  int inc_cnt = 0, ack_cnt = 0, ovf_cnt = 0, wcnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  eye_center_ctrl #(.TAP_W(6), .OBS_WORDS(OBS)) u_eye_center_ctrl (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .decode_err(decode_err),
    .lock_lost(lock_lost), .tap_inc(tap_inc), .step_done(step_done),
    .tap_ovf(tap_ovf), .tap_val(tap_val), .lock(lock));

  always #4 clk = ~clk;

  always @(negedge clk) begin
    int t;
    logic in1, in2;
    cyc++;
    t = int'(tap_val);
    in1 = (t >= a1 && t < b1);
    in2 = (t >= a2 && t < b2);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wcnt++;
    if ((in1 || in2) && (wcnt % 4 == 0)) word_in = CTL[(wcnt / 4) % 4];
    else begin
      word_in = lfsr[9:0];
      if (word_in == CTL[0] || word_in == CTL[1] || word_in == CTL[2] || word_in == CTL[3])
        word_in[5] = ~word_in[5];
    end
    decode_err = (e2 != 0) && in2;
    if (!rst_n) begin inc_cnt = 0; ack_cnt = 0; ovf_cnt = 0; end
    else begin
      if (tap_inc) inc_cnt++;
      if (step_done) ack_cnt++;
      if (tap_ovf) ovf_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_lock(input int limit, output int got);
    got = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (lock) begin got = 1; break; end
    end
  endtask

  initial begin
    int got;
    int held;
    a1 = 0; b1 = 0; a2 = 0; b2 = 0; e2 = 0;
    do_reset();
    check("R10 tap after reset", int'(tap_val), 0);
    check("R10 lock after reset", int'(lock), 0);
    check("R10 strobes after reset", int'(tap_inc) + int'(step_done), 0);

    for (int v = 0; v < NV; v++) begin
      a1 = VEC[v][0]; b1 = VEC[v][1]; a2 = VEC[v][2]; b2 = VEC[v][3]; e2 = VEC[v][4];
      do_reset();
      if (VEC[v][5] != 0) begin
        wait_lock(3000, got);
        check($sformatf("R5 R6 lock vec%0d", v), got, 1);
        check($sformatf("R7 center vec%0d", v), int'(tap_val), VEC[v][6]);
        check($sformatf("R2 step count vec%0d", v), inc_cnt, (a2 != 0) ? b2 : b1);
        check($sformatf("R3 ack count vec%0d", v), ack_cnt, inc_cnt);
        check($sformatf("R4 no overflow vec%0d", v), ovf_cnt, 0);
      end else begin
        wait_lock(1500, got);
        check($sformatf("R1 R4 no lock vec%0d", v), got, 0);
        check($sformatf("R4 overflow seen vec%0d", v), int'(ovf_cnt > 0), 1);
      end
    end

    a1 = 12; b1 = 30; a2 = 0; b2 = 0; e2 = 0;
    do_reset();
    wait_lock(3000, got);
    check("R7 lock before hold test", got, 1);
    a1 = 0; b1 = 0;
    held = inc_cnt;
    repeat (200) @(negedge clk);
    check("R8 lock held", int'(lock), 1);
    check("R8 tap held", int'(tap_val), 21);
    check("R8 no steps while locked", inc_cnt, held);

    lock_lost = 1;
    @(negedge clk);
    lock_lost = 0;
    check("R9 lock dropped", int'(lock), 0);
    check("R9 tap back to 0", int'(tap_val), 0);
    a1 = 5; b1 = 12;
    wait_lock(3000, got);
    check("R9 relock", got, 1);
    check("R9 relock center", int'(tap_val), 8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule